// File: doc/BRIEF.md
# Clock Configuration Profile Manager

This block sits inside a programmable clock generator and owns the working configuration that steers the synthesizer and its output stage. It holds a volatile register file covering the reference prescaler, the fractional feedback value, the PLL on/off control, one post-divider per output, the output mux selects and the output enables. These registers are loaded from a small read-only bank of stored profiles. The default profile is loaded when the block leaves reset. A multi-bit frequency-select pin picks another profile at run time, and that profile is copied into the working registers one word per clock.

A plain register-write port, which stands for the back end of a two-wire serial slave, lets a host rewrite single working words. Each change takes one of two routes. A change that touches only output gating, post-dividers or mux selects is applied at once. A change to any synthesizer word gates the outputs, pulses an update strobe to the PLL and waits for lock or a timeout before the outputs come back. Output enables only switch while the divided clock they gate is low, so no shortened pulse reaches a pin. While reset is held, the block sits in a low-power state. The clock pins and the host read-data and ready lines float until initialization has finished.

Top module: `clkcfg_mgr`

## Requirements
- R1: A stored profile word is `(q*257 + a*17 + 1) mod 65536`, where a is the word address and q is the profile index p for a >= 3 and p/2 (integer division) for a < 3. After reset is released, profile 0 is copied one word per cycle, addresses 0 to NREG-1, on the first NREG clock edges. With lock present, the block is idle and driving on the 11th edge.
- R2: While rst_n is low, lp_mode is 1 and drv_en is 0 (clk_out, host_rdata and host_rdy undriven). drv_en stays 0 and busy stays 1 until initialization returns to idle.
- R3: The working word layout is as follows. Address 0 bits [7:0] drive ref_div. Address 1 drives fbk_frac. Address 2 bit 0 drives pll_en. Addresses 3+i bits [7:0] drive post_div[8i+7:8i]. Address 3+NOUT bits [2*NOUT-1:0] drive mux_sel. Address 4+NOUT bit i enables output i.
- R4: fs_in passes through two flops and must hold a new value for STAB_CYC cycles. busy rises on the (STAB_CYC+4)-th edge after fs_in changes and not before. A value held for fewer cycles starts nothing.
- R5: A profile change copies the selected profile into all NREG words, one per cycle. When no synthesizer word changes, busy is high for exactly NREG cycles.
- R6: In idle, a host write (host_wr with host_rdy high) updates the addressed word on that edge and host_rdata reads it back. Stored profiles are not altered, so selecting the profile again restores its stored words.
- R7: host_rdy is low while busy. A host write presented then is dropped.
- R8: A write to address 3 or above, or a write of an unchanged value to addresses 0 to 2, is applied without busy and without a pll_upd pulse.
- R9: A write that changes address 0, 1 or 2 raises busy and pll_upd for exactly one cycle after the write edge. All outputs are gated until the block is idle again. With pll_lock high it is idle two edges after the write.
- R10: Without lock, the wait ends after TMO_CYC cycles. A slow write is busy for TMO_CYC+1 cycles, and a slow profile change for NREG+TMO_CYC+1 cycles.
- R11: A profile change whose words 0 to 2 differ from the working ones takes the slow route with one pll_upd pulse. If they are equal, it produces no pll_upd pulse.
- R12: clk_out[i] is clk_div_in[i] ANDed with an effective enable. The effective enable takes its new value only on an edge where clk_div_in[i] is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | External reset, synchronous, active low |
| fs_in | input | FS_W | Asynchronous frequency-select pins |
| host_wr | input | 1 | Host write request |
| host_addr | input | AW | Host word address (write and read) |
| host_wdata | input | REG_W | Host write data |
| host_rdata | output | REG_W | Working word at host_addr; floats during init |
| host_rdy | output | 1 | High when a write would be accepted; floats during init |
| pll_lock | input | 1 | Lock indication from the PLL |
| clk_div_in | input | NOUT | Divided clocks before gating |
| clk_out | output | NOUT | Gated output clocks; float during init |
| ref_div | output | RDIV_W | Reference prescaler value |
| fbk_frac | output | REG_W | Fractional feedback value |
| pll_en | output | 1 | PLL on/off |
| post_div | output | NOUT*PDIV_W | Per-output post-divider values |
| mux_sel | output | 2*NOUT | Per-output mux selects |
| pll_upd | output | 1 | One-cycle strobe that loads new PLL settings |
| busy | output | 1 | Sequence in progress |
| lp_mode | output | 1 | Low-power state during reset |
| drv_en | output | 1 | Pins and host outputs are driven |

## Verification
The bench targets the point where a frequency-select change becomes a copy. A synchronizer that is too short or too long, or a stability counter compared before it restarts, moves the busy edge by a cycle, and a short pulse on the pins then loads a profile. It separates the two apply routes by counting strobes and busy cycles. A design that strobes on every profile change, or never strobes, shows the wrong count, and so does one that forgets to time out when lock never comes. For gating, it holds a divided clock high across an enable change. A design that switches the enable without waiting for the low phase cuts or creates a pulse at the pin. It also writes during a copy and reloads a profile after host writes. These catch a port that accepts writes while busy and a write path that corrupts the stored bank.

// File: rtl/clkcfg_pkg.sv
// Shared definitions for the clock configuration profile manager.
// Assumes: word addresses 0..PLL_WORDS-1 hold synthesizer settings.
package clkcfg_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_COPY   = 2'd1,
        S_STROBE = 2'd2,
        S_WAIT   = 2'd3
    } seq_t;

    // Number of leading words that are synthesizer parameters (slow route)
    localparam int PLL_WORDS = 3;

    // Total working words for a given output count
    function automatic int word_count(input int nout);
        return PLL_WORDS + nout + 2;
    endfunction

endpackage

// File: rtl/clkcfg_prof_rom.sv
// Read-only profile bank, computed rather than tabled.
// Word(p,a) = q*257 + a*17 + 1, q = p/2 for synthesizer words, p otherwise,
// so neighbouring profiles share synthesizer settings.
// Assumes: purely combinational, address below NREG.
module clkcfg_prof_rom #(
    parameter int FS_W  = 2,
    parameter int AW    = 4,
    parameter int REG_W = 16
) (
    input  logic [FS_W-1:0]  prof,
    input  logic [AW-1:0]    addr,
    output logic [REG_W-1:0] word
);
    import clkcfg_pkg::*;

    // Form the stored word from profile and address
    always_comb begin
        int unsigned q;
        int unsigned tmp;
        q    = (int'(addr) < PLL_WORDS) ? (int'(prof) >> 1) : int'(prof);
        tmp  = q * 257 + int'(addr) * 17 + 1;
        word = tmp[REG_W-1:0];
    end
endmodule

// File: rtl/clkcfg_fs_filter.sv
// Frequency-select conditioner: two-flop synchronizer, then a stability
// counter. fs_ok is high once the synchronized value has held STAB_CYC cycles.
// Assumes: fs_in is asynchronous and slow compared with clk.
module clkcfg_fs_filter #(
    parameter int FS_W     = 2,
    parameter int STAB_CYC = 8,
    parameter int DEF_PROF = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FS_W-1:0] fs_in,
    output logic [FS_W-1:0] fs_val,
    output logic            fs_ok
);
    localparam int SW = $clog2(STAB_CYC + 1);

    logic [FS_W-1:0] fs_s1, fs_s2, fs_prev;
    logic [SW-1:0]   stab;

    // Synchronize and time how long the value has held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_s1   <= FS_W'(DEF_PROF);
            fs_s2   <= FS_W'(DEF_PROF);
            fs_prev <= FS_W'(DEF_PROF);
            stab    <= '0;
        end else begin
            fs_s1   <= fs_in;
            fs_s2   <= fs_s1;
            fs_prev <= fs_s2;
            if (fs_s2 != fs_prev)
                stab <= '0;
            else if (stab != SW'(STAB_CYC))
                stab <= stab + 1'b1;
        end
    end

    assign fs_val = fs_s2;
    assign fs_ok  = (stab == SW'(STAB_CYC)) && (fs_s2 == fs_prev);

    // A freshly changed select value is never reported as stable
    p_fs_glitch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_s2 != $past(fs_s2)) |-> !fs_ok);
endmodule

// File: rtl/clkcfg_out_gate.sv
// Output gating: each enable follows its target only while the divided clock
// it gates is low, so no shortened pulse appears at the pin.
// Assumes: divided clocks are slower than clk and are sampled as levels.
module clkcfg_out_gate #(
    parameter int NOUT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NOUT-1:0] en_tgt,
    input  logic [NOUT-1:0] clk_div_in,
    output logic [NOUT-1:0] gclk
);
    logic [NOUT-1:0] en_eff;

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        // Move the enable only during the low phase
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_eff[i] <= 1'b0;
            else if (!clk_div_in[i])
                en_eff[i] <= en_tgt[i];
        end

        assign gclk[i] = clk_div_in[i] & en_eff[i];

        p_en_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
            clk_div_in[i] |=> $stable(en_eff[i]));
    end
endmodule

// File: rtl/clkcfg_mgr.sv
// Clock configuration profile manager (top).
// Holds the working word file, loads profiles after reset and on
// frequency-select changes, takes host writes, and runs the fast or slow
// apply route. Pins and host outputs float until initialization completes.
// Assumes: pll_lock is synchronous to clk; synchronous active-low reset.
module clkcfg_mgr #(
    parameter int FS_W     = 2,
    parameter int NOUT     = 4,
    parameter int REG_W    = 16,
    parameter int RDIV_W   = 8,
    parameter int PDIV_W   = 8,
    parameter int STAB_CYC = 8,
    parameter int TMO_CYC  = 20,
    parameter int DEF_PROF = 0,
    localparam int NREG    = clkcfg_pkg::word_count(NOUT),
    localparam int AW      = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [FS_W-1:0]        fs_in,
    input  logic                   host_wr,
    input  logic [AW-1:0]          host_addr,
    input  logic [REG_W-1:0]       host_wdata,
    output logic [REG_W-1:0]       host_rdata,
    output logic                   host_rdy,
    input  logic                   pll_lock,
    input  logic [NOUT-1:0]        clk_div_in,
    output logic [NOUT-1:0]        clk_out,
    output logic [RDIV_W-1:0]      ref_div,
    output logic [REG_W-1:0]       fbk_frac,
    output logic                   pll_en,
    output logic [NOUT*PDIV_W-1:0] post_div,
    output logic [2*NOUT-1:0]      mux_sel,
    output logic                   pll_upd,
    output logic                   busy,
    output logic                   lp_mode,
    output logic                   drv_en
);
    import clkcfg_pkg::*;

    localparam int MUX_IDX = PLL_WORDS + NOUT;
    localparam int OEN_IDX = PLL_WORDS + NOUT + 1;
    localparam int CW      = $clog2(TMO_CYC + 1);

    seq_t              state;
    logic [AW-1:0]     idx;
    logic [FS_W-1:0]   prof, applied;
    logic [CW-1:0]     cnt;
    logic              gate_q, init_q, lp_q;
    logic [REG_W-1:0]  wreg [NREG];
    logic [REG_W-1:0]  rom_word, rd_i;
    logic [FS_W-1:0]   fs_val;
    logic              fs_ok;
    logic [NOUT-1:0]   en_tgt, gclk;

    clkcfg_prof_rom #(.FS_W(FS_W), .AW(AW), .REG_W(REG_W)) u_rom (
        .prof (prof),
        .addr (idx),
        .word (rom_word)
    );

    clkcfg_fs_filter #(.FS_W(FS_W), .STAB_CYC(STAB_CYC), .DEF_PROF(DEF_PROF)) u_fs (
        .clk    (clk),
        .rst_n  (rst_n),
        .fs_in  (fs_in),
        .fs_val (fs_val),
        .fs_ok  (fs_ok)
    );

    clkcfg_out_gate #(.NOUT(NOUT)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_tgt     (en_tgt),
        .clk_div_in (clk_div_in),
        .gclk       (gclk)
    );

    // Sequencer: copy, strobe, wait for lock, and host write handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_COPY;
            idx     <= '0;
            prof    <= FS_W'(DEF_PROF);
            applied <= FS_W'(DEF_PROF);
            cnt     <= '0;
            gate_q  <= 1'b1;
            init_q  <= 1'b1;
            lp_q    <= 1'b1;
            for (int k = 0; k < NREG; k++) wreg[k] <= '0;
        end else begin
            lp_q <= 1'b0;
            case (state)
                S_COPY: begin
                    wreg[idx] <= rom_word;
                    if (int'(idx) < PLL_WORDS && rom_word != wreg[idx])
                        gate_q <= 1'b1;
                    if (idx == AW'(NREG - 1)) begin
                        idx <= '0;
                        if (gate_q || (int'(idx) < PLL_WORDS && rom_word != wreg[idx]))
                            state <= S_STROBE;
                        else
                            state <= S_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_STROBE: begin
                    state <= S_WAIT;
                    cnt   <= '0;
                end
                S_WAIT: begin
                    if (pll_lock || cnt == CW'(TMO_CYC - 1)) begin
                        state  <= S_IDLE;
                        gate_q <= 1'b0;
                        init_q <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (host_wr) begin
                        if (int'(host_addr) < NREG) begin
                            wreg[host_addr] <= host_wdata;
                            if (int'(host_addr) < PLL_WORDS && host_wdata != wreg[host_addr]) begin
                                gate_q <= 1'b1;
                                state  <= S_STROBE;
                            end
                        end
                    end else if (fs_ok && fs_val != applied) begin
                        state   <= S_COPY;
                        idx     <= '0;
                        prof    <= fs_val;
                        applied <= fs_val;
                    end
                end
            endcase
        end
    end

    // Enable target: all off while a slow change or init is pending
    assign en_tgt = gate_q ? '0 : wreg[OEN_IDX][NOUT-1:0];

    // Host read mux
    assign rd_i = (int'(host_addr) < NREG) ? wreg[host_addr] : '0;

    // Field outputs from the working words
    assign ref_div  = wreg[0][RDIV_W-1:0];
    assign fbk_frac = wreg[1];
    assign pll_en   = wreg[2][0];
    assign mux_sel  = wreg[MUX_IDX][2*NOUT-1:0];
    for (genvar i = 0; i < NOUT; i++) begin : g_pdiv
        assign post_div[i*PDIV_W +: PDIV_W] = wreg[PLL_WORDS + i][PDIV_W-1:0];
    end

    // Status and pin drivers
    assign pll_upd    = (state == S_STROBE);
    assign busy       = (state != S_IDLE);
    assign lp_mode    = lp_q;
    assign drv_en     = !init_q;
    assign host_rdata = init_q ? 'z : rd_i;
    assign host_rdy   = init_q ? 1'bz : (state == S_IDLE);
    assign clk_out    = init_q ? 'z : gclk;

    // Strobe lasts one cycle and is followed by the wait
    p_upd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pll_upd |=> (!pll_upd && busy));

    // Copy advances one word per cycle
    p_copy_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COPY && idx != AW'(NREG - 1)) |=> (state == S_COPY && idx == $past(idx) + 1'b1));

    // Drivers only come on when the sequence has finished
    p_drv_after_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> !busy);

    // Lock wait never exceeds its timeout
    p_wait_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) |-> (int'(cnt) < TMO_CYC));
endmodule

// File: tb/tb_clkcfg_mgr.sv
module tb_clkcfg_mgr;
    localparam int NOUT = 4, NREG = 9, STAB = 8, TMO = 20;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [1:0]  fs_in = 2'd0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    wire  [15:0] host_rdata;
    wire         host_rdy;
    logic        pll_lock = 1'b1;
    logic [3:0]  clk_div_in = '0;
    wire  [3:0]  clk_out;
    wire  [7:0]  ref_div;
    wire  [15:0] fbk_frac;
    wire         pll_en;
    wire  [31:0] post_div;
    wire  [7:0]  mux_sel;
    wire         pll_upd, busy, lp_mode, drv_en;

    int n_chk = 0, n_fail = 0, busy_n = 0, upd_n = 0;
    logic [15:0] ex [NREG];

    clkcfg_mgr dut (
        .clk(clk), .rst_n(rst_n), .fs_in(fs_in), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rdy(host_rdy), .pll_lock(pll_lock), .clk_div_in(clk_div_in),
        .clk_out(clk_out), .ref_div(ref_div), .fbk_frac(fbk_frac), .pll_en(pll_en),
        .post_div(post_div), .mux_sel(mux_sel), .pll_upd(pll_upd), .busy(busy),
        .lp_mode(lp_mode), .drv_en(drv_en)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (busy) busy_n++;
        if (pll_upd) upd_n++;
    end

    // {slow, addr, data}: host write vectors
    localparam logic [20:0] VEC [7] = '{
        {1'b0, 4'd3, 16'h0005},
        {1'b0, 4'd7, 16'h00E4},
        {1'b0, 4'd8, 16'h000F},
        {1'b1, 4'd1, 16'h1234},
        {1'b0, 4'd1, 16'h1234},
        {1'b1, 4'd0, 16'h0003},
        {1'b1, 4'd2, 16'h0000}
    };

    function automatic logic [15:0] pword(input int p, input int a);
        int q;
        q = (a < 3) ? p / 2 : p;
        return 16'(q * 257 + a * 17 + 1);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic hw(input logic [3:0] a, input logic [15:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic read_prof(input int p, input string tag);
        for (int a = 0; a < NREG; a++) begin
            host_addr = 4'(a);
            #1;
            chk(tag, 32'(host_rdata), 32'(pword(p, a)));
        end
    endtask

    task automatic chk_fields(input string tag);
        chk({tag, " ref_div"}, 32'(ref_div), 32'(ex[0][7:0]));
        chk({tag, " frac"}, 32'(fbk_frac), 32'(ex[1]));
        chk({tag, " pll_en"}, 32'(pll_en), 32'(ex[2][0]));
        chk({tag, " mux"}, 32'(mux_sel), 32'(ex[7][7:0]));
        for (int i = 0; i < NOUT; i++)
            chk({tag, " post_div"}, 32'(post_div[i*8 +: 8]), 32'(ex[3+i][7:0]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R2: reset state
        tick(3);
        chk("R2 lp during reset", 32'(lp_mode), 1);
        chk("R2 drv_en during reset", 32'(drv_en), 0);
        rst_n = 1'b1;
        // R1: default load timing; strobe after the last copy edge
        tick(9);
        chk("R1 strobe after copy", 32'(pll_upd), 1);
        tick(1);
        chk("R2 still undriven", 32'(drv_en), 0);
        chk("R2 busy during init", 32'(busy), 1);
        tick(1);
        chk("R1 idle after init", 32'(busy), 0);
        chk("R2 driven after init", 32'(drv_en), 1);
        chk("R2 lp cleared", 32'(lp_mode), 0);
        read_prof(0, "R1 default profile");
        for (int a = 0; a < NREG; a++) ex[a] = pword(0, a);
        chk_fields("R3 init fields");

        // Vector loop: R6, R8, R9 host writes
        for (int v = 0; v < 7; v++) begin
            logic slow;
            slow = VEC[v][20];
            hw(VEC[v][19:16], VEC[v][15:0]);
            chk("R8/R9 busy after write", 32'(busy), 32'(slow));
            chk("R8/R9 strobe after write", 32'(pll_upd), 32'(slow));
            if (slow) begin
                tick(1);
                chk("R9 strobe single", 32'(pll_upd), 0);
                tick(1);
                chk("R9 lock exit", 32'(busy), 0);
            end
            ex[VEC[v][19:16]] = VEC[v][15:0];
            host_addr = VEC[v][19:16];
            #1;
            chk("R6 readback", 32'(host_rdata), 32'(VEC[v][15:0]));
            chk_fields("R3 fields");
        end

        // R4 exact start; R7 write during copy; R5 load; R11 slow load
        upd_n = 0;
        fs_in = 2'd1;
        tick(STAB + 3);
        chk("R4 not yet started", 32'(busy), 0);
        tick(1);
        chk("R4 start edge", 32'(busy), 1);
        chk("R7 rdy low while busy", 32'(host_rdy), 0);
        hw(4'd3, 16'hAAAA);
        while (busy) tick(1);
        read_prof(1, "R5/R7 profile 1 loaded");
        chk("R11 slow load strobe", 32'(upd_n), 1);

        // R5/R11 fast load back to 0; R6 stored profile intact
        upd_n = 0; busy_n = 0;
        fs_in = 2'd0;
        tick(STAB + 3 + NREG + 3);
        chk("R11 no strobe on fast load", 32'(upd_n), 0);
        chk("R5 fast busy length", 32'(busy_n), NREG);
        read_prof(0, "R6 stored profile intact");

        // R4 glitch on select
        busy_n = 0;
        fs_in = 2'd3;
        tick(4);
        fs_in = 2'd0;
        tick(30);
        chk("R4 short select ignored", 32'(busy_n), 0);
        chk("R4 frac unchanged", 32'(fbk_frac), 32'(pword(0, 1)));

        // R10 timeout on profile 2 (PLL off, no lock)
        pll_lock = 1'b0; busy_n = 0; upd_n = 0;
        fs_in = 2'd2;
        tick(STAB + 4 + NREG + TMO + 10);
        chk("R10 slow load busy length", 32'(busy_n), NREG + TMO + 1);
        chk("R11 strobe on profile 2", 32'(upd_n), 1);
        chk("R3 pll_en from profile 2", 32'(pll_en), 0);

        // R9 gating during a slow write, R10 write timeout, R12 enable timing
        hw(4'd1, 16'h4321);
        chk("R9 strobe", 32'(pll_upd), 1);
        tick(1);
        clk_div_in = 4'hF;
        tick(1);
        chk("R9 outputs gated", 32'(clk_out), 0);
        tick(TMO - 2);
        chk("R10 still waiting", 32'(busy), 1);
        tick(1);
        chk("R10 timeout exit", 32'(busy), 0);
        tick(2);
        chk("R12 no enable while high", 32'(clk_out), 0);
        clk_div_in = 4'h0;
        tick(1);
        clk_div_in = 4'hF;
        #1;
        chk("R12 enable applied in low phase", 32'(clk_out), 32'(pword(2, 8) & 16'hF));
        @(negedge clk);
        hw(4'd8, 16'h0000);
        tick(3);
        chk("R12 disable held while high", 32'(clk_out), 32'(pword(2, 8) & 16'hF));
        clk_div_in = 4'h0;
        tick(1);
        clk_div_in = 4'hF;
        #1;
        chk("R12 disabled after low phase", 32'(clk_out), 0);
        pll_lock = 1'b1;
        clk_div_in = 4'h0;

        // R2/R1 reset mid-run reloads the default profile
        @(negedge clk);
        fs_in = 2'd0;
        rst_n = 1'b0;
        tick(3);
        chk("R2 lp on re-reset", 32'(lp_mode), 1);
        chk("R2 undriven on re-reset", 32'(drv_en), 0);
        rst_n = 1'b1;
        tick(11);
        chk("R2 driven after re-init", 32'(drv_en), 1);
        read_prof(0, "R1 reload after reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule